// File: doc/BRIEF.md
# Single-Register Transfer Address Generator

This block forms the memory request for a load or store of one register. It takes the base register value, the addressing control bits and either an immediate field or an already shifted register offset. From these it produces three results. The first is the address of the access. The second is the new base value, together with an enable that says whether it is written back. The third, for loads, is the returned data extended to the full register width. The block also drives the byte lanes and store data a 32-bit little-endian memory needs, for word, halfword and byte sizes.

The access takes one cycle to issue and one cycle to return. When `op_valid` is high at a clock edge, the request appears for exactly one cycle after that edge, with the writeback result beside it. Memory presents `mem_rdata` during that request cycle. The extended load result appears in the following cycle.

Two operation groups exist. The word group (`op_grp_half` = 0) moves words, or unsigned bytes when `wg_byte` = 1. The halfword group (`op_grp_half` = 1) moves halfwords when `hg_half` = 1, and signed bytes on load when `hg_half` = 0. Register file access and the offset shifter sit outside the block.

Top module: `mem_xfer_agu`

## Requirements
- R1: The immediate offset magnitude is `imm_field[11:0]` in the word group. In the halfword group it is the 8-bit value {`imm_field[11:8]`, `imm_field[3:0]`}, so bits [7:4] have no effect on the address.
- R2: With `off_sel_reg` = 1 the offset magnitude is `off_reg`; otherwise it is the immediate of R1. The offset is added when `dir_up` = 1 and subtracted when `dir_up` = 0.
- R3: With `pre_idx` = 1 the access address is base + offset; with `pre_idx` = 0 it is the unmodified base.
- R4: `wb_en` is high with the request unless `pre_idx` = 1 and `wr_back` = 0. `wb_value` always equals base + offset.
- R5: With `base_is_pc` = 1 the base reads as `base_val` + 8. With `off_is_pc` = 1 (register offset) the offset magnitude reads as `off_reg` + 8 before the direction of R2 is applied.
- R6: `op_valid` high at edge N gives `mem_req` high for exactly the cycle after N, with `mem_addr`, `mem_we` (= not `is_load`), `mem_be`, `mem_wdata`, `wb_en` and `wb_value` valid in that cycle. A load then gives `ld_valid` high for one cycle after that, with `ld_data` built from the `mem_rdata` seen in the request cycle. A store gives no `ld_valid`.
- R7: A halfword load takes bits [15:0] of the addressed half. It sign-extends from bit 15 when `hg_signed` = 1 and zero-extends otherwise.
- R8: A halfword-group byte load (`hg_half` = 0) sign-extends the addressed byte from bit 7.
- R9: A word-group byte load zero-extends the addressed byte. A byte store copies `store_data[7:0]` onto all four lanes of `mem_wdata`.
- R10: `mem_be` is one-hot at lane `addr[1:0]` for bytes, `4'b0011` or `4'b1100` (chosen by `addr[1]`) for halfwords, and `4'b1111` for words. A halfword store copies `store_data[15:0]` into both halves. Loads take the byte at lane `addr[1:0]` or the half selected by `addr[1]`.
- R11: During and right after reset, `mem_req`, `wb_en` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue one transfer this cycle |
| op_grp_half | input | 1 | 0 = word group, 1 = halfword group |
| is_load | input | 1 | 1 = load, 0 = store |
| pre_idx | input | 1 | Apply the offset before the access |
| dir_up | input | 1 | 1 = add offset, 0 = subtract |
| wr_back | input | 1 | Write back the base when pre-indexed |
| wg_byte | input | 1 | Word group: byte instead of word |
| hg_half | input | 1 | Halfword group: halfword instead of byte |
| hg_signed | input | 1 | Halfword group: sign-extend a halfword load |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| off_sel_reg | input | 1 | Use the register offset instead of the immediate |
| off_reg | input | 32 | Shifted register offset value |
| off_is_pc | input | 1 | Offset register is the program counter |
| imm_field | input | 12 | Immediate offset field |
| store_data | input | 32 | Register value to store |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Access address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Store data placed on lanes |
| mem_rdata | input | 32 | Read data during the request cycle |
| wb_en | output | 1 | Write `wb_value` back to the base register |
| wb_value | output | 32 | Updated base value |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions check the following on every cycle: the request and response handshake timing, the lane-enable count for each size, the copying of byte store data onto all lanes, the sign fill of signed byte loads, and the equality of the written-back base and the access address when a pre-indexed access writes back. Only the bench scenarios can show the arithmetic itself. This covers the two-nibble immediate, the subtracted offset, the extra 8 added for a program-counter base or offset, the difference between pre and post addresses, and the lane chosen by each address for each size and extension mode.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } xfer_size_e;
endpackage

// File: rtl/xfer_offset_gen.sv
module xfer_offset_gen #(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 12,
  parameter int PC_AHEAD = 8
) (
  input  logic              grp_half,
  input  logic              sel_reg,
  input  logic              reg_is_pc,
  input  logic              dir_up,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_off,
  output logic [DATA_W-1:0] offset
);
  localparam int SPLIT_W = 8;

  logic [SPLIT_W-1:0] split_imm;
  logic [DATA_W-1:0]  imm_mag;
  logic [DATA_W-1:0]  reg_mag;
  logic [DATA_W-1:0]  mag;

  // The halfword form joins the top and bottom nibbles; the middle nibble is dropped
  assign split_imm = {imm[IMM_W-1 -: 4], imm[3:0]};

  always_comb begin
    if (grp_half) imm_mag = {{(DATA_W-SPLIT_W){1'b0}}, split_imm};
    else          imm_mag = {{(DATA_W-IMM_W){1'b0}}, imm};
    reg_mag = reg_off + (reg_is_pc ? DATA_W'(PC_AHEAD) : '0);
    mag     = sel_reg ? reg_mag : imm_mag;
    offset  = dir_up ? mag : (~mag + 1'b1);
  end
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic              base_is_pc,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              pre_idx,
  input  logic              wr_back,
  output logic [DATA_W-1:0] acc_addr,
  output logic [DATA_W-1:0] new_base,
  output logic              base_upd
);
  logic [DATA_W-1:0] base_eff;
  logic [DATA_W-1:0] sum;

  always_comb begin
    base_eff = base + (base_is_pc ? DATA_W'(PC_AHEAD) : '0);
    sum      = base_eff + offset;
    acc_addr = pre_idx ? sum : base_eff;
    new_base = sum;
    base_upd = !(pre_idx && !wr_back);
  end
endmodule

// File: rtl/xfer_lane_ctl.sv
module xfer_lane_ctl
  import xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  xfer_size_e        size,
  input  logic [LSB_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] st_data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[i]          = (addr_lo == LSB_W'(i));
          wdata[8*i +: 8] = st_data[7:0];
        end
        SZ_HALF: begin
          be[i]          = ((addr_lo >> 1) == LSB_W'(i / 2));
          wdata[8*i +: 8] = st_data[8*(i % 2) +: 8];
        end
        default: begin
          be[i]          = 1'b1;
          wdata[8*i +: 8] = st_data[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/xfer_load_ext.sv
module xfer_load_ext
  import xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  xfer_size_e        size,
  input  logic              sign_ext,
  input  logic [LSB_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ld_val
);
  logic [DATA_W-1:0] by_shift;
  logic [DATA_W-1:0] hw_shift;
  logic [7:0]        by_lane;
  logic [15:0]       hw_lane;

  always_comb begin
    by_shift = rdata >> {addr_lo, 3'b000};
    hw_shift = rdata >> {addr_lo[LSB_W-1:1], 4'b0000};
    by_lane  = by_shift[7:0];
    hw_lane  = hw_shift[15:0];
    unique case (size)
      SZ_BYTE: ld_val = {{(DATA_W-8){sign_ext & by_lane[7]}}, by_lane};
      SZ_HALF: ld_val = {{(DATA_W-16){sign_ext & hw_lane[15]}}, hw_lane};
      default: ld_val = rdata;
    endcase
  end
endmodule

// File: rtl/mem_xfer_agu.sv
module mem_xfer_agu
  import xfer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 12,
  parameter int PC_AHEAD = 8,
  localparam int LANES   = DATA_W / 8,
  localparam int LSB_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_grp_half,
  input  logic              is_load,
  input  logic              pre_idx,
  input  logic              dir_up,
  input  logic              wr_back,
  input  logic              wg_byte,
  input  logic              hg_half,
  input  logic              hg_signed,
  input  logic [DATA_W-1:0] base_val,
  input  logic              base_is_pc,
  input  logic              off_sel_reg,
  input  logic [DATA_W-1:0] off_reg,
  input  logic              off_is_pc,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [DATA_W-1:0] store_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_value,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Access size and extension decode
  xfer_size_e size_c;
  logic       sext_c;

  always_comb begin
    if (op_grp_half) begin
      size_c = hg_half ? SZ_HALF : SZ_BYTE;
      sext_c = hg_half ? hg_signed : 1'b1;
    end else begin
      size_c = wg_byte ? SZ_BYTE : SZ_WORD;
      sext_c = 1'b0;
    end
  end

  logic [DATA_W-1:0] offset_c;
  logic [DATA_W-1:0] addr_c;
  logic [DATA_W-1:0] nbase_c;
  logic              upd_c;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wdata_c;

  xfer_offset_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W), .PC_AHEAD(PC_AHEAD)) u_off (
    .grp_half  (op_grp_half),
    .sel_reg   (off_sel_reg),
    .reg_is_pc (off_is_pc),
    .dir_up    (dir_up),
    .imm       (imm_field),
    .reg_off   (off_reg),
    .offset    (offset_c)
  );

  xfer_addr_gen #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_addr (
    .base_is_pc (base_is_pc),
    .base       (base_val),
    .offset     (offset_c),
    .pre_idx    (pre_idx),
    .wr_back    (wr_back),
    .acc_addr   (addr_c),
    .new_base   (nbase_c),
    .base_upd   (upd_c)
  );

  xfer_lane_ctl #(.DATA_W(DATA_W)) u_lane (
    .size    (size_c),
    .addr_lo (addr_c[LSB_W-1:0]),
    .st_data (store_data),
    .be      (be_c),
    .wdata   (wdata_c)
  );

  // Request stage
  logic              req_q,   req_d;
  logic              we_q,    we_d;
  logic [DATA_W-1:0] addr_q,  addr_d;
  logic [LANES-1:0]  be_q,    be_d;
  logic [DATA_W-1:0] wd_q,    wd_d;
  logic              wbe_q,   wbe_d;
  logic [DATA_W-1:0] wbv_q,   wbv_d;
  logic              pre_q,   pre_d;
  logic              sext_q,  sext_d;
  xfer_size_e        size_q,  size_d;
  // Response stage
  logic              ldv_q,   ldv_d;
  logic [DATA_W-1:0] ldd_q,   ldd_d;
  logic [DATA_W-1:0] ext_c;

  xfer_load_ext #(.DATA_W(DATA_W)) u_ext (
    .size     (size_q),
    .sign_ext (sext_q),
    .addr_lo  (addr_q[LSB_W-1:0]),
    .rdata    (mem_rdata),
    .ld_val   (ext_c)
  );

  always_comb begin
    req_d  = op_valid;
    wbe_d  = op_valid & upd_c;
    we_d   = we_q;
    addr_d = addr_q;
    be_d   = be_q;
    wd_d   = wd_q;
    wbv_d  = wbv_q;
    pre_d  = pre_q;
    sext_d = sext_q;
    size_d = size_q;
    if (op_valid) begin
      we_d   = !is_load;
      addr_d = addr_c;
      be_d   = be_c;
      wd_d   = wdata_c;
      wbv_d  = nbase_c;
      pre_d  = pre_idx;
      sext_d = sext_c;
      size_d = size_c;
    end
    ldv_d = req_q & !we_q;
    ldd_d = ldv_d ? ext_c : ldd_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      wbe_q  <= 1'b0;
      wbv_q  <= '0;
      pre_q  <= 1'b0;
      sext_q <= 1'b0;
      size_q <= SZ_WORD;
      ldv_q  <= 1'b0;
      ldd_q  <= '0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      be_q   <= be_d;
      wd_q   <= wd_d;
      wbe_q  <= wbe_d;
      wbv_q  <= wbv_d;
      pre_q  <= pre_d;
      sext_q <= sext_d;
      size_q <= size_d;
      ldv_q  <= ldv_d;
      ldd_q  <= ldd_d;
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wd_q;
  assign wb_en     = wbe_q;
  assign wb_value  = wbv_q;
  assign ld_valid  = ldv_q;
  assign ld_data   = ldd_q;

  // Assertions
  p_req_follows_op_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid |=> mem_req);
  p_load_answers_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && !mem_we) |=> ld_valid);
  p_no_spurious_ld_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_req && !mem_we) |=> !ld_valid);
  p_wb_only_with_req_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_en |-> mem_req);
  p_pre_wb_addr_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && wb_en && pre_q) |-> (wb_value == mem_addr));
  p_byte_lane_one_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && size_q == SZ_BYTE) |-> ($countones(mem_be) == 1));
  p_half_lane_two_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && size_q == SZ_HALF) |-> ($countones(mem_be) == 2));
  p_byte_store_copy_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && mem_we && size_q == SZ_BYTE) |-> (mem_wdata == {LANES{mem_wdata[7:0]}}));
  p_signed_byte_fill_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ld_valid && $past(size_q == SZ_BYTE && sext_q))
      |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));
endmodule

// File: tb/sim_mem_xfer_agu.sv
`timescale 1ns/1ps
module sim_mem_xfer_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_grp_half, is_load, pre_idx, dir_up, wr_back;
  logic        wg_byte, hg_half, hg_signed, base_is_pc, off_sel_reg, off_is_pc;
  logic [31:0] base_val, off_reg, store_data, mem_rdata;
  logic [11:0] imm_field;
  logic        mem_req, mem_we, wb_en, ld_valid;
  logic [31:0] mem_addr, mem_wdata, wb_value, ld_data;
  logic [3:0]  mem_be;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mem_xfer_agu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_grp_half(op_grp_half),
    .is_load(is_load), .pre_idx(pre_idx), .dir_up(dir_up), .wr_back(wr_back),
    .wg_byte(wg_byte), .hg_half(hg_half), .hg_signed(hg_signed),
    .base_val(base_val), .base_is_pc(base_is_pc), .off_sel_reg(off_sel_reg),
    .off_reg(off_reg), .off_is_pc(off_is_pc), .imm_field(imm_field),
    .store_data(store_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_value(wb_value),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic defaults();
    op_valid = 0; op_grp_half = 0; is_load = 1; pre_idx = 1; dir_up = 1;
    wr_back = 0; wg_byte = 0; hg_half = 0; hg_signed = 0; base_is_pc = 0;
    off_sel_reg = 0; off_is_pc = 0; base_val = 0; off_reg = 0;
    imm_field = 0; store_data = 0; mem_rdata = 0;
  endtask

  // Pulse op_valid for one edge; leaves the bench at the negedge of the request cycle
  task automatic issue();
    @(negedge clk); op_valid = 1;
    @(negedge clk); op_valid = 0;
  endtask

  // R2 R3 R4 R10: word load, pre-indexed, no writeback
  task automatic t_word_load_pre();
    defaults(); base_val = 32'h1000; imm_field = 12'h010; mem_rdata = 32'hCAFEBABE;
    issue();
    chk("R6", "req", {31'd0, mem_req}, 1);
    chk("R3", "pre addr", mem_addr, 32'h1010);
    chk("R4", "no wb", {31'd0, wb_en}, 0);
    chk("R10", "word be", {28'd0, mem_be}, 32'hF);
    chk("R6", "we", {31'd0, mem_we}, 0);
    @(negedge clk);
    chk("R6", "req one cycle", {31'd0, mem_req}, 0);
    chk("R6", "ld_valid", {31'd0, ld_valid}, 1);
    chk("R6", "word data", ld_data, 32'hCAFEBABE);
    @(negedge clk);
    chk("R6", "ld_valid pulse", {31'd0, ld_valid}, 0);
  endtask

  // R2 R3 R4: word store post-indexed downward
  task automatic t_word_store_post();
    defaults(); is_load = 0; pre_idx = 0; dir_up = 0; base_val = 32'h2000;
    imm_field = 12'h004; store_data = 32'h11223344;
    issue();
    chk("R3", "post addr", mem_addr, 32'h2000);
    chk("R4", "post wb_en", {31'd0, wb_en}, 1);
    chk("R2", "down wb", wb_value, 32'h1FFC);
    chk("R6", "store we", {31'd0, mem_we}, 1);
    chk("R10", "word wdata", mem_wdata, 32'h11223344);
    @(negedge clk);
    chk("R6", "no ld after store", {31'd0, ld_valid}, 0);
    chk("R4", "wb_en pulse", {31'd0, wb_en}, 0);
  endtask

  // R2 R4: register offset subtracted, pre with writeback
  task automatic t_reg_off_wb();
    defaults(); off_sel_reg = 1; off_reg = 32'h30; dir_up = 0; wr_back = 1;
    base_val = 32'h3000; imm_field = 12'hFFF;
    issue();
    chk("R2", "reg off addr", mem_addr, 32'h2FD0);
    chk("R4", "pre wb_en", {31'd0, wb_en}, 1);
    chk("R4", "pre wb value", wb_value, 32'h2FD0);
    @(negedge clk);
  endtask

  // R1 R7 R10: split immediate, signed and unsigned halfwords on both halves
  task automatic t_half_loads();
    defaults(); op_grp_half = 1; hg_half = 1; hg_signed = 1; base_val = 32'h4000;
    imm_field = 12'h3F6; mem_rdata = 32'h8001_1234;
    issue();
    chk("R1", "split imm addr", mem_addr, 32'h4036);
    chk("R10", "upper half be", {28'd0, mem_be}, 32'hC);
    @(negedge clk);
    chk("R7", "signed upper half", ld_data, 32'hFFFF8001);
    hg_signed = 0;
    issue(); @(negedge clk);
    chk("R7", "unsigned upper half", ld_data, 32'h00008001);
    hg_signed = 1; imm_field = 12'h3F4; mem_rdata = 32'h8001_F234;
    issue();
    chk("R10", "lower half be", {28'd0, mem_be}, 32'h3);
    @(negedge clk);
    chk("R7", "signed lower half", ld_data, 32'hFFFFF234);
  endtask

  // R8: signed byte loads in the halfword group
  task automatic t_signed_byte();
    defaults(); op_grp_half = 1; hg_half = 0; base_val = 32'h5000;
    imm_field = 12'h003; mem_rdata = 32'h9A00_0000;
    issue();
    chk("R10", "lane3 be", {28'd0, mem_be}, 32'h8);
    @(negedge clk);
    chk("R8", "neg byte", ld_data, 32'hFFFFFF9A);
    imm_field = 12'h002; mem_rdata = 32'h007F_0000;
    issue(); @(negedge clk);
    chk("R8", "pos byte", ld_data, 32'h0000007F);
  endtask

  // R9: word-group byte load and byte store
  task automatic t_word_group_byte();
    defaults(); wg_byte = 1; base_val = 32'h6000; imm_field = 12'h001;
    mem_rdata = 32'h0000_F100;
    issue();
    chk("R10", "lane1 be", {28'd0, mem_be}, 32'h2);
    @(negedge clk);
    chk("R9", "zero-ext byte", ld_data, 32'h000000F1);
    is_load = 0; imm_field = 12'h002; store_data = 32'hDEADBEEF;
    issue();
    chk("R10", "lane2 be", {28'd0, mem_be}, 32'h4);
    chk("R9", "byte store copy", mem_wdata, 32'hEFEFEFEF);
    @(negedge clk);
  endtask

  // R10: halfword store lanes
  task automatic t_half_store();
    defaults(); op_grp_half = 1; hg_half = 1; is_load = 0; base_val = 32'h7000;
    imm_field = 12'h002; store_data = 32'h1234ABCD;
    issue();
    chk("R10", "half store be", {28'd0, mem_be}, 32'hC);
    chk("R10", "half store data", mem_wdata, 32'hABCDABCD);
    @(negedge clk);
  endtask

  // R5: program counter as base and as offset register
  task automatic t_pc_reads();
    defaults(); base_is_pc = 1; base_val = 32'h8000; imm_field = 12'h004;
    issue();
    chk("R5", "pc base pre", mem_addr, 32'h800C);
    @(negedge clk);
    pre_idx = 0;
    issue();
    chk("R5", "pc base post addr", mem_addr, 32'h8008);
    chk("R5", "pc base post wb", wb_value, 32'h800C);
    @(negedge clk);
    defaults(); base_val = 32'h9000; off_sel_reg = 1; off_is_pc = 1;
    off_reg = 32'h100; dir_up = 0;
    issue();
    chk("R5", "pc offset down", mem_addr, 32'h8EF8);
    @(negedge clk);
  endtask

  initial begin
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R11", "reset req", {31'd0, mem_req}, 0);
    chk("R11", "reset wb", {31'd0, wb_en}, 0);
    chk("R11", "reset ld", {31'd0, ld_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R11", "idle req", {31'd0, mem_req}, 0);
    t_word_load_pre();
    t_word_store_post();
    t_reg_off_wb();
    t_half_loads();
    t_signed_byte();
    t_word_group_byte();
    t_half_store();
    t_pc_reads();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule